// File: doc/BRIEF.md
# VGA Colour-Stepping Screen Tester

This block drives a VGA monitor with a single solid colour that fills the whole visible area. The colour steps through all 64 codes of a 2-bit-per-channel palette, so a technician can watch how the tube responds to each colour in turn. It runs from a low and imprecise pixel clock of about 8 MHz and produces active-low horizontal and vertical sync. Its three 2-bit colour outputs feed an external resistor ladder.

Line and frame timing come from free-running power-of-two counters. An 8-bit pixel counter sets a 256-clock line, and a 9-bit line counter sets a 512-line frame. Two small phase state machines sit on these counters, one per axis. Each has four states:

- ACTIVE: visible region.
- FRONT: front porch.
- SYNC: sync pulse.
- BACK: back porch.

The machines move through ACTIVE → FRONT → SYNC → BACK → ACTIVE. Each transition fires when the counter reaches the last position of the current phase. The vertical machine only steps on the line-advance strobe. That strobe marks the cycle in which horizontal sync rises (SYNC → BACK).

A slow strobe input feeds a 4-bit divider. Every sixteenth strobe advances the 6-bit colour register. With the strobe at 16 Hz, each colour is shown for one second.

Top module: `vga_color_cycler`

## Requirements
- R1: The displayed colour maps to the outputs as red = colour[5:4], green = colour[3:2], blue = colour[1:0].
- R2: `hsync_n_o` is low for exactly 29 consecutive clocks and high for 227, giving a 256-clock line.
- R3: Within a line, colour is driven for 196 consecutive clocks. It starts 24 clocks after the clock in which `hsync_n_o` rises, and is followed by 7 dark clocks before `hsync_n_o` falls.
- R4: The line counter advances in the clock in which `hsync_n_o` rises. After reset, `vsync_n_o` falls at the 494th such rise (480 visible lines plus 14 front-porch lines). `vsync_n_o` changes only in clocks in which `hsync_n_o` rises.
- R5: `vsync_n_o` stays low for exactly 2 lines (512 clocks).
- R6: Exactly 480 lines per frame carry colour. Outputs are 0 while either sync is low and throughout vertical blanking.
- R7: The colour register advances by one on every 16th clock in which `tick_i` is high, and fifteen strobes leave it unchanged.
- R8: The colour wraps from 63 to 0.
- R9: `rst_i` high asynchronously forces both syncs high and the colour outputs to 0. It clears the pixel counter, line counter, divider and colour, so the first clock sampled after release is pixel 1 and horizontal sync first falls 203 clocks after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock, about 8 MHz |
| rst_i | input | 1 | Asynchronous reset, active high |
| tick_i | input | 1 | Slow strobe; sixteen strobes advance the colour |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| red_o | output | 2 | Red level to the DAC |
| green_o | output | 2 | Green level to the DAC |
| blue_o | output | 2 | Blue level to the DAC |

## Verification
The colour path is tried with several strobe patterns:

- fifteen strobes, which must leave the colour unchanged;
- a sixteenth strobe;
- a long burst to code 27, whose three unequal fields expose any swapped channel;
- a burst to code 63 followed by one more step, which separates a wrap to zero from saturation.

Horizontal timing is measured edge to edge on a lit line, so a shifted porch shows up apart from a wrong sync width. A whole frame is then traced from reset. That trace counts lit lines, the line on which vertical sync falls, and its width, which tells a wrong vertical threshold apart from a wrong line-advance point. A reset applied during a sync pulse checks that the clear is asynchronous.

// File: rtl/vgacc_pkg.sv
package vgacc_pkg;

    // Phase of one scan axis; the order is the scan order.
    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_FRONT  = 2'd1,
        PH_SYNC   = 2'd2,
        PH_BACK   = 2'd3
    } phase_e;

endpackage

// File: rtl/vgacc_hgen.sv
// Horizontal scan: free-running pixel counter plus phase machine.
module vgacc_hgen
    import vgacc_pkg::*;
#(
    parameter int CNT_BITS = 8,
    parameter int VIS      = 196,
    parameter int FP       = 7,
    parameter int SW       = 29
) (
    input  logic   clk_i,
    input  logic   rst_i,
    output phase_e phase_o,
    output logic   sync_n_o,
    output logic   adv_o
);
    localparam int TOTAL    = 1 << CNT_BITS;
    localparam int SYNC_BEG = VIS + FP;
    localparam int SYNC_END = SYNC_BEG + SW;

    localparam logic [CNT_BITS-1:0] LAST_ACT  = CNT_BITS'(VIS - 1);
    localparam logic [CNT_BITS-1:0] LAST_FP   = CNT_BITS'(SYNC_BEG - 1);
    localparam logic [CNT_BITS-1:0] LAST_SYNC = CNT_BITS'(SYNC_END - 1);
    localparam logic [CNT_BITS-1:0] LAST_BP   = CNT_BITS'(TOTAL - 1);

    logic [CNT_BITS-1:0] cnt_q;
    phase_e              state_q;
    phase_e              state_d;

    // Counter wraps naturally at 2**CNT_BITS.
    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_ACTIVE: if (cnt_q == LAST_ACT)  state_d = PH_FRONT;
            PH_FRONT:  if (cnt_q == LAST_FP)   state_d = PH_SYNC;
            PH_SYNC:   if (cnt_q == LAST_SYNC) state_d = PH_BACK;
            PH_BACK:   if (cnt_q == LAST_BP)   state_d = PH_ACTIVE;
        endcase
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            state_q <= PH_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        phase_o  = state_q;
        sync_n_o = (state_q != PH_SYNC);
        // Line advances on the edge at which sync returns high.
        adv_o    = (state_q == PH_SYNC) && (cnt_q == LAST_SYNC);
    end

endmodule

// File: rtl/vgacc_vgen.sv
// Vertical scan: line counter stepped by the line-advance strobe.
module vgacc_vgen
    import vgacc_pkg::*;
#(
    parameter int CNT_BITS = 9,
    parameter int VIS      = 480,
    parameter int FP       = 14,
    parameter int SW       = 2
) (
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   adv_i,
    output phase_e phase_o,
    output logic   sync_n_o
);
    localparam int TOTAL    = 1 << CNT_BITS;
    localparam int SYNC_BEG = VIS + FP;
    localparam int SYNC_END = SYNC_BEG + SW;

    localparam logic [CNT_BITS-1:0] LAST_ACT  = CNT_BITS'(VIS - 1);
    localparam logic [CNT_BITS-1:0] LAST_FP   = CNT_BITS'(SYNC_BEG - 1);
    localparam logic [CNT_BITS-1:0] LAST_SYNC = CNT_BITS'(SYNC_END - 1);
    localparam logic [CNT_BITS-1:0] LAST_BP   = CNT_BITS'(TOTAL - 1);

    logic [CNT_BITS-1:0] line_q;
    phase_e              state_q;
    phase_e              state_d;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            line_q <= '0;
        end else if (adv_i) begin
            line_q <= line_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        if (adv_i) begin
            unique case (state_q)
                PH_ACTIVE: if (line_q == LAST_ACT)  state_d = PH_FRONT;
                PH_FRONT:  if (line_q == LAST_FP)   state_d = PH_SYNC;
                PH_SYNC:   if (line_q == LAST_SYNC) state_d = PH_BACK;
                PH_BACK:   if (line_q == LAST_BP)   state_d = PH_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            state_q <= PH_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        phase_o  = state_q;
        sync_n_o = (state_q != PH_SYNC);
    end

endmodule

// File: rtl/vgacc_color.sv
// Strobe divider and wrapping colour register.
module vgacc_color #(
    parameter int DIV_BITS   = 4,
    parameter int COLOR_BITS = 6
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  tick_i,
    output logic [COLOR_BITS-1:0] color_o
);
    logic [DIV_BITS-1:0]   div_q;
    logic [COLOR_BITS-1:0] color_q;
    logic                  step;

    assign step = tick_i && (&div_q);

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            div_q <= '0;
        end else if (tick_i) begin
            div_q <= div_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            color_q <= '0;
        end else if (step) begin
            color_q <= color_q + 1'b1;
        end
    end

    assign color_o = color_q;

endmodule

// File: rtl/vga_color_cycler.sv
module vga_color_cycler
    import vgacc_pkg::*;
#(
    parameter int H_BITS   = 8,
    parameter int H_VIS    = 196,
    parameter int H_FP     = 7,
    parameter int H_SW     = 29,
    parameter int V_BITS   = 9,
    parameter int V_VIS    = 480,
    parameter int V_FP     = 14,
    parameter int V_SW     = 2,
    parameter int DIV_BITS = 4,
    parameter int CH_BITS  = 2
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               tick_i,
    output logic               hsync_n_o,
    output logic               vsync_n_o,
    output logic [CH_BITS-1:0] red_o,
    output logic [CH_BITS-1:0] green_o,
    output logic [CH_BITS-1:0] blue_o
);
    localparam int COLOR_BITS = 3 * CH_BITS;

    phase_e                h_phase;
    phase_e                v_phase;
    logic                  h_sync_n;
    logic                  v_sync_n;
    logic                  line_adv;
    logic [COLOR_BITS-1:0] color_w;
    logic                  visible;

    vgacc_hgen #(
        .CNT_BITS (H_BITS),
        .VIS      (H_VIS),
        .FP       (H_FP),
        .SW       (H_SW)
    ) u_hgen (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .phase_o  (h_phase),
        .sync_n_o (h_sync_n),
        .adv_o    (line_adv)
    );

    vgacc_vgen #(
        .CNT_BITS (V_BITS),
        .VIS      (V_VIS),
        .FP       (V_FP),
        .SW       (V_SW)
    ) u_vgen (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .adv_i    (line_adv),
        .phase_o  (v_phase),
        .sync_n_o (v_sync_n)
    );

    vgacc_color #(
        .DIV_BITS   (DIV_BITS),
        .COLOR_BITS (COLOR_BITS)
    ) u_color (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tick_i  (tick_i),
        .color_o (color_w)
    );

    // Output process: colour only while both axes are in ACTIVE.
    always_comb begin
        visible   = (h_phase == PH_ACTIVE) && (v_phase == PH_ACTIVE);
        hsync_n_o = h_sync_n;
        vsync_n_o = v_sync_n;
        if (visible) begin
            red_o   = color_w[3*CH_BITS-1:2*CH_BITS];
            green_o = color_w[2*CH_BITS-1:CH_BITS];
            blue_o  = color_w[CH_BITS-1:0];
        end else begin
            red_o   = '0;
            green_o = '0;
            blue_o  = '0;
        end
    end

endmodule

// File: rtl/vgacc_chk.sv
module vgacc_chk #(
    parameter int COLOR_BITS = 6
) (
    input logic                  clk_i,
    input logic                  rst_i,
    input logic                  tick_i,
    input logic                  hsync_n_o,
    input logic                  vsync_n_o,
    input logic [COLOR_BITS-1:0] rgb,
    input logic [COLOR_BITS-1:0] color_w
);
    // R2
    hsync_min_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(hsync_n_o) |=> !hsync_n_o);

    // R4
    vsync_on_line_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(vsync_n_o) |-> $rose(hsync_n_o));

    // R6
    dark_in_hsync_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !hsync_n_o |-> (rgb == '0));

    // R6
    dark_in_vsync_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !vsync_n_o |-> (rgb == '0));

    // R7
    color_needs_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(color_w) |-> $past(tick_i));

    // R8
    color_step_one_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(color_w) |-> (color_w == COLOR_BITS'($past(color_w) + 1'b1)));

    // R9
    reset_quiet_chk: assert property (@(posedge clk_i)
        rst_i |-> (hsync_n_o && vsync_n_o && (rgb == '0)));

endmodule

bind vga_color_cycler vgacc_chk #(.COLOR_BITS(3 * CH_BITS)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .tick_i    (tick_i),
    .hsync_n_o (hsync_n_o),
    .vsync_n_o (vsync_n_o),
    .rgb       ({red_o, green_o, blue_o}),
    .color_w   (color_w)
);

// File: tb/vga_color_cycler_tb.sv
`timescale 1ns/1ps
module vga_color_cycler_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       tick = 1'b0;
    logic       hs_n, vs_n;
    logic [1:0] red, green, blue;
    logic [5:0] rgb;
    int         vectors = 0;
    int         fails = 0;
    int         cycles = 0;

    assign rgb = {red, green, blue};

    vga_color_cycler u_dut (
        .clk_i     (clk),
        .rst_i     (rst),
        .tick_i    (tick),
        .hsync_n_o (hs_n),
        .vsync_n_o (vs_n),
        .red_o     (red),
        .green_o   (green),
        .blue_o    (blue)
    );

    always #10 clk = ~clk;

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 195000) begin
            vectors++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<195000", cycles);
            finish_run();
        end
    end

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_n(int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    // Returns at the negedge sample where hsync has just risen.
    task automatic wait_hs_rise();
        logic prev;
        prev = hs_n;
        forever begin
            @(negedge clk);
            if (!prev && hs_n) break;
            prev = hs_n;
        end
    endtask

    task automatic sample_mid_line(output logic [5:0] val);
        wait_hs_rise();
        repeat (40) @(negedge clk);
        val = rgb;
    endtask

    // R9: asynchronous reset during a sync pulse, then restart position
    task automatic t_reset();
        int n;
        @(negedge clk);
        while (hs_n) @(negedge clk);
        #2 rst = 1'b1;
        #1;
        check("R9 hsync high in reset", int'(hs_n), 1);
        check("R9 vsync high in reset", int'(vs_n), 1);
        check("R9 colour dark in reset", int'(rgb), 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (hs_n && n < 400);
        check("R9 first hsync fall after release", n, 203);
    endtask

    // R7 R1: divider and field mapping
    task automatic t_color_steps();
        logic [5:0] v;
        tick_n(15);
        sample_mid_line(v);
        check("R7 fifteen strobes no step", int'(v), 0);
        tick_n(1);
        sample_mid_line(v);
        check("R7 sixteenth strobe steps", int'(v), 1);
        tick_n(416);
        sample_mid_line(v);
        check("R1 red field of code 27", int'(v[5:4]), 1);
        check("R1 green field of code 27", int'(v[3:2]), 2);
        check("R1 blue field of code 27", int'(v[1:0]), 3);
    endtask

    // R2 R3: horizontal timing on a lit line
    task automatic t_hline();
        int n;
        wait_hs_rise();
        n = 0;
        while (rgb == 0) begin n++; @(negedge clk); end
        check("R3 back porch clocks", n, 24);
        n = 0;
        while (rgb != 0) begin n++; @(negedge clk); end
        check("R3 visible clocks", n, 196);
        n = 0;
        while (hs_n) begin n++; @(negedge clk); end
        check("R3 front porch clocks", n, 7);
        n = 0;
        while (!hs_n) begin n++; @(negedge clk); end
        check("R2 hsync low clocks", n, 29);
        n = 0;
        while (hs_n) begin n++; @(negedge clk); end
        check("R2 hsync high clocks", n, 227);
    endtask

    // R8: wrap 63 -> 0
    task automatic t_wrap();
        logic [5:0] v;
        tick_n(36 * 16);
        sample_mid_line(v);
        check("R8 reaches 63", int'(v), 63);
        tick_n(16);
        sample_mid_line(v);
        check("R8 wraps to 0", int'(v), 0);
    endtask

    // R4 R5 R6: one frame traced from reset
    task automatic t_frame();
        int  rises, lit_lines, vs_low, rises_at_fall, dark_bad;
        logic prev_hs, prev_vs, lit, seen_fall;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rises = 0; lit_lines = 0; vs_low = 0; rises_at_fall = -1;
        dark_bad = 0; lit = 1'b0; seen_fall = 1'b0;
        prev_hs = 1'b1; prev_vs = 1'b1;
        fork
            tick_n(16);
            begin
                forever begin
                    @(negedge clk);
                    if (!prev_hs && hs_n) begin
                        rises++;
                        if (lit) lit_lines++;
                        lit = 1'b0;
                    end
                    if (rgb != 0) lit = 1'b1;
                    if (prev_vs && !vs_n) begin
                        rises_at_fall = rises;
                        seen_fall = 1'b1;
                    end
                    if (!vs_n) begin
                        vs_low++;
                        if (rgb != 0) dark_bad++;
                    end
                    if (seen_fall && vs_n) break;
                    prev_hs = hs_n;
                    prev_vs = vs_n;
                end
            end
        join
        if (lit) lit_lines++;
        check("R4 hsync rises before vsync falls", rises_at_fall, 494);
        check("R5 vsync low clocks", vs_low, 512);
        check("R6 lit lines per frame", lit_lines, 480);
        check("R6 colour during vsync", dark_bad, 0);
    endtask

    initial begin
        #5 rst = 1'b1;
        @(negedge clk);
        check("R9 hsync after reset", int'(hs_n), 1);
        check("R9 vsync after reset", int'(vs_n), 1);
        check("R9 colour after reset", int'(rgb), 0);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_color_steps();
        t_hline();
        t_wrap();
        t_frame();
        finish_run();
    end

endmodule